// File: doc/BRIEF.md
# Time-Multiplexed Dense Layer

This block evaluates one fully connected neural network layer. It collects a whole input volume of `IN_X*IN_Y*IN_Z` signed samples from an AXI4-Stream slave into a local buffer. It then computes `N_OUT` output neurons and returns them as a vector on an AXI4-Stream master. Each output is the neuron's bias plus the dot product of the input with that neuron's weight row. An optional rectifier can be applied to each output.

The hardware has `N_CH` multiply-accumulate lanes, where `N_CH` may be anything from 1 up to `N_OUT`. The neurons are processed in groups of `N_CH`. Each group takes one cycle per input element plus one cycle to add the bias, and then emits its results. Raising `N_CH` cuts latency and costs area.

Weights and biases are held in a register bank that can be written at run time. A frame computes with a snapshot of that bank taken when its last input sample arrives. A write made while the frame is being computed therefore applies only to later frames.

Top module: `dense_layer`

## Requirements
- R1: After reset, `s_tready` is 1 and `m_tvalid` is 0, and every weight and bias reads as zero.
- R2: A frame is exactly `N_IN = IN_X*IN_Y*IN_Z` accepted beats. Samples arrive with X outermost, then Y, then Z innermost, so the flat index is k = (x*IN_Y + y)*IN_Z + z. `s_tready` is high only while a frame is being collected. Beats offered while `s_tready` is low are not taken.
- R3: Coefficient word address n*(N_IN+1)+k holds the weight linking neuron n to input k. Address n*(N_IN+1)+N_IN holds the bias of neuron n. A write with an address of `N_OUT*(N_IN+1)` or above changes nothing.
- R4: Each result is the full-precision signed value bias + Σ x[k]*w[n][k], `AW = DW+WW+clog2(N_IN+1)` bits wide, with no overflow or rounding.
- R5: With `RELU_EN=1`, a negative result is emitted as 0. A non-negative result passes unchanged.
- R6: `m_tvalid` rises exactly `N_IN+1` clock edges after one of two edges: the edge that accepts the last beat of a frame, or the edge that accepts the last result of the previous group.
- R7: A frame yields `N_OUT` output beats in ascending neuron order. `m_tlast` is 1 only on neuron `N_OUT-1`, and after that beat is accepted the block returns to collecting input.
- R8: While `m_tvalid` is 1 and `m_tready` is 0, `m_tdata` and `m_tlast` hold their values.
- R9: Writes in cycles up to and including the edge of a frame's last input beat apply to that frame. Writes after that edge apply only to later frames.
- R10: When `N_CH` does not divide `N_OUT`, the last group emits only the remaining neurons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tvalid | input | 1 | Input sample valid |
| s_tready | output | 1 | Ready to accept an input sample |
| s_tdata | input | DW | Signed input sample |
| m_tvalid | output | 1 | Result valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | AW | Signed (rectified) result |
| m_tlast | output | 1 | Last neuron of the vector |
| wr_en | input | 1 | Coefficient write strobe |
| wr_addr | input | ADW | Coefficient word address |
| wr_data | input | WW | Signed weight or bias value |

## Verification
A bad counter or group index shows at the ports on the next beat, as a result emitted too early or too late, or as a value taken from the wrong weight row. A wrong snapshot of the coefficient bank only appears once the frame's results come out, about `N_IN+1` cycles later. The bench models timing and values on every clock, so a stray extra cycle or a swapped lane fails on the first beat it affects. Value errors are checked with backpressure, input bubbles, back-to-back frames, and writes made during computation.

// File: rtl/dense_pkg.sv
package dense_pkg;
    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_MAC  = 2'd1,
        PH_EMIT = 2'd2
    } phase_e;
endpackage

// File: rtl/dense_wstore.sv
// Coefficient bank: a writable shadow copy plus an active copy frozen per frame.
module dense_wstore #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 5,
    parameter int N_CH  = 2,
    parameter int WW    = 8,
    parameter int GW    = 2,
    parameter int KW    = 4,
    parameter int ADW   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADW-1:0]           wr_addr,
    input  logic [WW-1:0]            wr_data,
    input  logic                     snap,
    input  logic [GW-1:0]            rd_grp,
    input  logic [KW-1:0]            rd_idx,
    output logic [N_CH-1:0][WW-1:0]  rd_w
);
    localparam int NWORDS = N_OUT * (N_IN + 1);

    logic [WW-1:0] sh_d [NWORDS];
    logic [WW-1:0] sh_q [NWORDS];
    logic [WW-1:0] ac_d [NWORDS];
    logic [WW-1:0] ac_q [NWORDS];

    always_comb begin
        sh_d = sh_q;
        ac_d = ac_q;
        if (wr_en && (int'(wr_addr) < NWORDS)) begin
            sh_d[wr_addr] = wr_data;
        end
        if (snap) begin
            ac_d = sh_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) begin
                sh_q[i] <= '0;
                ac_q[i] <= '0;
            end
        end else begin
            sh_q <= sh_d;
            ac_q <= ac_d;
        end
    end

    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            rd_w[c] = '0;
            if ((int'(rd_grp) * N_CH + c) < N_OUT) begin
                rd_w[c] = ac_q[ADW'((int'(rd_grp) * N_CH + c) * (N_IN + 1) + int'(rd_idx))];
            end
        end
    end

    // R9: the active bank moves only on a snapshot
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap) ##1 ($stable(rd_grp) && $stable(rd_idx)) |-> $stable(rd_w));
endmodule

// File: rtl/dense_mac.sv
// One multiply-accumulate lane: load on the first element, add bias on the last cycle.
module dense_mac #(
    parameter int DW = 8,
    parameter int WW = 8,
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          first,
    input  logic          bias_cyc,
    input  logic [DW-1:0] x,
    input  logic [WW-1:0] w,
    output logic [AW-1:0] acc
);
    logic signed [AW-1:0]    acc_d, acc_q;
    logic signed [DW+WW-1:0] prod;

    always_comb begin
        prod  = $signed(x) * $signed(w);
        acc_d = acc_q;
        if (en) begin
            if (first) begin
                acc_d = AW'(prod);
            end else if (bias_cyc) begin
                acc_d = acc_q + AW'($signed(w));
            end else begin
                acc_d = acc_q + AW'(prod);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

    // R6: a lane holds its result while not computing (emission window)
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q));
endmodule

// File: rtl/dense_layer.sv
module dense_layer #(
    parameter int IN_X    = 2,
    parameter int IN_Y    = 2,
    parameter int IN_Z    = 2,
    parameter int N_OUT   = 5,
    parameter int N_CH    = 2,
    parameter int DW      = 8,
    parameter int WW      = 8,
    parameter bit RELU_EN = 1'b1,
    localparam int N_IN   = IN_X * IN_Y * IN_Z,
    localparam int NWORDS = N_OUT * (N_IN + 1),
    localparam int ADW    = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int AW     = DW + WW + $clog2(N_IN + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s_tvalid,
    output logic           s_tready,
    input  logic [DW-1:0]  s_tdata,
    output logic           m_tvalid,
    input  logic           m_tready,
    output logic [AW-1:0]  m_tdata,
    output logic           m_tlast,
    input  logic           wr_en,
    input  logic [ADW-1:0] wr_addr,
    input  logic [WW-1:0]  wr_data
);
    import dense_pkg::*;

    localparam int NGRP = (N_OUT + N_CH - 1) / N_CH;
    localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int CW   = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int KW   = $clog2(N_IN + 1);

    typedef struct packed {
        phase_e        ph;
        logic [KW-1:0] cnt;
        logic [GW-1:0] grp;
        logic [CW-1:0] ch;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [DW-1:0] xb_d [N_IN];
    logic [DW-1:0] xb_q [N_IN];

    logic                     snap, lane_en, first, bias_cyc, last_nrn;
    logic [DW-1:0]            x_cur;
    logic [N_CH-1:0][WW-1:0]  rd_w;
    logic [AW-1:0]            acc [N_CH];
    logic [AW-1:0]            sel;

    always_comb begin
        ctl_d    = ctl_q;
        xb_d     = xb_q;
        snap     = 1'b0;
        lane_en  = 1'b0;
        s_tready = (ctl_q.ph == PH_LOAD);
        m_tvalid = (ctl_q.ph == PH_EMIT);
        last_nrn = (int'(ctl_q.grp) * N_CH + int'(ctl_q.ch)) == (N_OUT - 1);
        first    = (ctl_q.cnt == '0);
        bias_cyc = (ctl_q.cnt == KW'(N_IN));
        x_cur    = bias_cyc ? '0 : xb_q[ctl_q.cnt];
        case (ctl_q.ph)
            PH_LOAD: begin
                if (s_tvalid) begin
                    xb_d[ctl_q.cnt] = s_tdata;
                    if (ctl_q.cnt == KW'(N_IN - 1)) begin
                        ctl_d.cnt = '0;
                        ctl_d.grp = '0;
                        ctl_d.ph  = PH_MAC;
                        snap      = 1'b1;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
            end
            PH_MAC: begin
                lane_en = 1'b1;
                if (bias_cyc) begin
                    ctl_d.ph = PH_EMIT;
                    ctl_d.ch = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            PH_EMIT: begin
                if (m_tready) begin
                    if (last_nrn) begin
                        ctl_d.ph  = PH_LOAD;
                        ctl_d.cnt = '0;
                    end else if (ctl_q.ch == CW'(N_CH - 1)) begin
                        ctl_d.grp = ctl_q.grp + 1'b1;
                        ctl_d.ch  = '0;
                        ctl_d.cnt = '0;
                        ctl_d.ph  = PH_MAC;
                    end else begin
                        ctl_d.ch = ctl_q.ch + 1'b1;
                    end
                end
            end
            default: ctl_d.ph = PH_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_LOAD, cnt: '0, grp: '0, ch: '0};
            for (int i = 0; i < N_IN; i++) xb_q[i] <= '0;
        end else begin
            ctl_q <= ctl_d;
            xb_q  <= xb_d;
        end
    end

    dense_wstore #(
        .N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH), .WW(WW),
        .GW(GW), .KW(KW), .ADW(ADW)
    ) u_wstore (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .snap(snap), .rd_grp(ctl_q.grp),
        .rd_idx(ctl_q.cnt), .rd_w(rd_w)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_lane
        dense_mac #(.DW(DW), .WW(WW), .AW(AW)) u_mac (
            .clk(clk), .rst_n(rst_n), .en(lane_en), .first(first),
            .bias_cyc(bias_cyc), .x(x_cur), .w(rd_w[c]), .acc(acc[c])
        );
    end

    assign sel     = acc[ctl_q.ch];
    assign m_tlast = m_tvalid && last_nrn;

    if (RELU_EN) begin : g_relu
        assign m_tdata = sel[AW-1] ? '0 : sel;
        // R5: a rectified result is never negative
        p_relu_r5: assert property (@(posedge clk) disable iff (!rst_n)
            m_tvalid |-> !m_tdata[AW-1]);
    end else begin : g_linear
        assign m_tdata = sel;
    end

    // R8: output is held under backpressure
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

    // R7: accepting the final neuron returns the block to input collection
    p_last_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && m_tready && m_tlast |=> s_tready && !m_tvalid);

    // R2: the final input beat closes the input side
    p_frame_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_tvalid && s_tready && (ctl_q.cnt == KW'(N_IN - 1)) |=> !s_tready && !m_tvalid);
endmodule

// File: tb/test_dense_layer.sv
`timescale 1ns/1ps
module test_dense_layer;
    localparam int IN_X = 2, IN_Y = 2, IN_Z = 2;
    localparam int N_OUT = 5, N_CH = 2, DW = 8, WW = 8;
    localparam int N_IN = IN_X * IN_Y * IN_Z;
    localparam int NW = N_OUT * (N_IN + 1);
    localparam int ADW = $clog2(NW);
    localparam int AW = DW + WW + $clog2(N_IN + 1);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           s_tvalid = 1'b0, s_tready;
    logic [DW-1:0]  s_tdata = '0;
    logic           m_tvalid, m_tready = 1'b1, m_tlast;
    logic [AW-1:0]  m_tdata;
    logic           wr_en = 1'b0;
    logic [ADW-1:0] wr_addr = '0;
    logic [WW-1:0]  wr_data = '0;

    dense_layer #(.IN_X(IN_X), .IN_Y(IN_Y), .IN_Z(IN_Z), .N_OUT(N_OUT),
                  .N_CH(N_CH), .DW(DW), .WW(WW), .RELU_EN(1'b1)) i_dense_layer (
        .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tdata(s_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tdata(m_tdata), .m_tlast(m_tlast), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data));

    int n_chk = 0, n_fail = 0, cyc = 0;
    int shw [NW];
    int actw [NW];
    int xin [$];
    int expq [$];
    int mph = 0, waitc = 0, grp_left = 0;
    bit bp_mode = 1'b0, done = 1'b0;
    string tag = "R4";

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(string rq, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", rq, cyc, act, exp);
        end
    endtask

    function automatic int wval(int a, int set);
        return ((a * 7 + set * 5 + 3) % 13) - 6;
    endfunction

    function automatic int xval(int f, int k);
        return ((f * 11 + k * 5) % 15) - 7;
    endfunction

    // Reference model, advanced on each edge from pre-edge inputs
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mph = 0;
            xin.delete();
            expq.delete();
            for (int i = 0; i < NW; i++) shw[i] = 0;
        end else begin
            if (wr_en && int'(wr_addr) < NW) shw[wr_addr] = int'($signed(wr_data));
            case (mph)
                0: if (s_tvalid) begin
                    xin.push_back(int'($signed(s_tdata)));
                    if (xin.size() == N_IN) begin
                        actw = shw;
                        for (int n = 0; n < N_OUT; n++) begin
                            int r;
                            r = actw[n * (N_IN + 1) + N_IN];
                            for (int k = 0; k < N_IN; k++) r += xin[k] * actw[n * (N_IN + 1) + k];
                            expq.push_back(r < 0 ? 0 : r);
                        end
                        xin.delete();
                        mph = 1; waitc = N_IN + 1;
                        grp_left = (N_OUT < N_CH) ? N_OUT : N_CH;
                    end
                end
                1: begin
                    waitc--;
                    if (waitc == 0) mph = 2;
                end
                default: if (m_tready) begin
                    void'(expq.pop_front());
                    grp_left--;
                    if (expq.size() == 0) mph = 0;
                    else if (grp_left == 0) begin
                        mph = 1; waitc = N_IN + 1;
                        grp_left = (expq.size() < N_CH) ? expq.size() : N_CH;
                    end
                end
            endcase
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 s_tready", int'(s_tready), int'(mph == 0));
            chk("R6 m_tvalid", int'(m_tvalid), int'(mph == 2));
            if (mph == 2 && m_tvalid) begin
                chk({tag, " m_tdata"}, int'($signed(m_tdata)), expq[0]);
                chk("R7 m_tlast", int'(m_tlast), int'(expq.size() == 1));
            end
        end
    end

    always @(negedge clk) m_tready <= bp_mode ? (cyc % 3 != 0) : 1'b1;

    task automatic wr(int a, int v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADW'(a); wr_data = WW'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_frame(int f, bit gaps);
        for (int k = 0; k < N_IN; k++) begin
            @(negedge clk);
            if (gaps && (k % 2 == 1)) begin
                s_tvalid = 1'b0;
                @(negedge clk);
            end
            s_tvalid = 1'b1;
            s_tdata = DW'(xval(f, k));
            do @(posedge clk); while (!s_tready);
        end
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    task automatic drain();
        while (mph != 0 || expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 s_tready after reset", int'(s_tready), 1);
        chk("R1 m_tvalid after reset", int'(m_tvalid), 0);
        // R1: untouched bank gives all-zero results
        tag = "R1"; send_frame(9, 1'b0); drain();

        // R3: address map neuron-major, bias last
        for (int a = 0; a < NW; a++) wr(a, wval(a, 0));
        // R10 partial last group, R4 values
        tag = "R10"; send_frame(0, 1'b0); drain();
        // R8 backpressure
        bp_mode = 1'b1; tag = "R8"; send_frame(1, 1'b0); drain(); bp_mode = 1'b0;
        // R5 rectifier and R4 back-to-back frames
        tag = "R5"; send_frame(2, 1'b0); send_frame(3, 1'b0);
        tag = "R4"; send_frame(4, 1'b0); drain();
        // R9: writes during computation apply from the next frame
        tag = "R9"; send_frame(5, 1'b0);
        for (int a = 0; a < NW; a += 4) wr(a, wval(a, 1));
        drain();
        send_frame(5, 1'b0); drain();
        // R3: out-of-range addresses are dropped
        tag = "R3"; wr(NW, 99); wr(NW + 5, -77); wr((1 << ADW) - 1, 55);
        send_frame(6, 1'b0); drain();
        // R2: input bubbles and scan order
        tag = "R2"; bp_mode = 1'b1; send_frame(7, 1'b1); drain();
        done = 1'b1;
        summary();
    end
endmodule